// File: doc/BRIEF.md
# Service-Acknowledge Context Controller

This block sits beside the parallel channel of a multi-channel peripheral. It turns that channel's pending conditions into a service request toward the host. It also answers the hardware acknowledge cycle that follows the request. Two sources feed it with one-cycle event pulses: the data path and the channel-control state machine. Each source has its own status register, which the host clears by writing ones, and its own enable mask. The service request is raised whenever an enabled status bit is set and no service is under way.

While the active-low acknowledge input is low, the block places a vector on the read-data bus. The top five bits of that vector are programmed by the host. The bottom three bits say which source types are pending. The block keeps track of which channel context is currently selected. At the first cycle of an acknowledge, it saves that context on a two-entry stack and switches the context to channel 0. No separate register is needed to report the requesting channel, because channel 0 is always the requester on this path.

When service is done, the host writes any value to the end-of-service address. That write pops the stack and puts back the context that was selected before the acknowledge.

Top module: `svc_ctx_ctrl`

## Requirements
- R1: After reset, the context is 0, and both status registers, both enable masks, the stack depth and the overflow flag are all 0. The service request is low.
- R2: Data-path status sits at address 2 and its enable mask at address 3. Channel-control status sits at address 4 and its enable mask at address 5. An event pulse on input bit i sets status bit i in the next cycle. Writing the status address clears exactly the bits written as 1. If an event and a clearing write hit the same bit in the same cycle, the event wins.
- R3: `svc_req` is high exactly when some status bit with its enable bit set is pending and the stack depth is 0.
- R4: Address 1 is the vector register. Writes store bits 7:3. Reads return those bits, with the low three bits coded as follows: bit 0 = enabled data-path condition pending, bit 1 = enabled channel-control condition pending, bit 2 = 0. When the host decodes the vector, bit 0 takes priority over bit 1.
- R5: While `ack_n` is low, `rdata` carries the vector, whatever the values of `rd_en` and `addr`.
- R6: At the first clock edge with `ack_n` low after it was high, the current context is pushed and the context becomes 0. While `ack_n` is held low after that, no further push happens.
- R7: Address 7 reads {overflow, 5'b0, depth[1:0]}. If an acknowledge starts while the stack already holds two entries, the overflow flag is set and stays set, the stored entries are left unchanged, and the context still becomes 0. Writing bit 7 = 1 to address 7 clears the flag.
- R8: Writing any value to address 6 pops the stack, and the popped entry becomes the context. The same write with an empty stack has no effect.
- R9: An end-of-service write in the same cycle that an acknowledge starts is ignored. The push still takes place.
- R10: Address 0 reads and writes the context in bits 1:0, and the context is also driven on `ctx_chan`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data; carries the vector during acknowledge |
| ack_n | input | 1 | Service acknowledge, active low |
| dp_evt | input | 4 | Data-path condition event pulses |
| cc_evt | input | 4 | Channel-control condition event pulses |
| svc_req | output | 1 | Service request |
| ctx_chan | output | 2 | Currently selected channel context |

## Verification
The hardest situation to reach is a stack that is already full when a further acknowledge arrives. Getting there needs three acknowledge cycles with no end-of-service write in between. Before each acknowledge, the bench writes a different context value, so that the pops that follow show exactly which entries survived the overflow. A second hard case is an acknowledge edge and an end-of-service write landing in the same cycle. The bench drives both strobes on one falling edge, then pops twice to show that the push happened and the pop did not.

// File: rtl/svc_ctx_pkg.sv
package svc_ctx_pkg;
    localparam int DW = 8;

    typedef enum logic [2:0] {
        A_CTX = 3'd0,
        A_VEC = 3'd1,
        A_DPS = 3'd2,
        A_DPE = 3'd3,
        A_CCS = 3'd4,
        A_CCE = 3'd5,
        A_EOS = 3'd6,
        A_STK = 3'd7
    } reg_addr_e;
endpackage

// File: rtl/svc_stat.sv
module svc_stat #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic         clr_we,
    input  logic         en_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] stat,
    output logic [W-1:0] en,
    output logic         pend
);
    typedef struct packed {
        logic [W-1:0] st;
        logic [W-1:0] en;
    } stat_t;

    stat_t d, q;

    always_comb begin
        d = q;
        if (clr_we) d.st = q.st & ~wdata;
        d.st = d.st | evt;
        if (en_we) d.en = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign stat = q.st;
    assign en   = q.en;
    assign pend = |(q.st & q.en);

    p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((stat & $past(evt)) == $past(evt)));

    p_w1c_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && !(|evt)) |=> ((stat & $past(wdata)) == '0));
endmodule

// File: rtl/svc_ctx_stack.sv
module svc_ctx_stack #(
    parameter int DEPTH = 2,
    parameter int W     = 2,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  push_val,
    output logic [W-1:0]  top_val,
    output logic [CW-1:0] depth,
    output logic          full,
    output logic          empty
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [CW-1:0]           cnt;
    } stk_t;

    stk_t d, q;

    assign full  = (q.cnt == CW'(DEPTH));
    assign empty = (q.cnt == '0);
    assign depth = q.cnt;

    always_comb begin
        top_val = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (CW'(i + 1) == q.cnt) top_val = q.mem[i];
        end
    end

    always_comb begin
        d = q;
        if (push) begin
            if (!full) begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (CW'(i) == q.cnt) d.mem[i] = push_val;
                end
                d.cnt = q.cnt + 1'b1;
            end
        end else if (pop && !empty) begin
            d.cnt = q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    p_depth_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        depth <= CW'(DEPTH));

    p_empty_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && empty) |=> (depth == '0));

    p_full_push_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |=> $stable(q.mem));
endmodule

// File: rtl/svc_ctx_ctrl.sv
module svc_ctx_ctrl
    import svc_ctx_pkg::*;
#(
    parameter int CH_W      = 2,
    parameter int DP_W      = 4,
    parameter int CC_W      = 4,
    parameter int STK_DEPTH = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            rd_en,
    input  logic [2:0]      addr,
    input  logic [7:0]      wdata,
    output logic [7:0]      rdata,
    input  logic            ack_n,
    input  logic [DP_W-1:0] dp_evt,
    input  logic [CC_W-1:0] cc_evt,
    output logic            svc_req,
    output logic [CH_W-1:0] ctx_chan
);
    localparam int CW = $clog2(STK_DEPTH + 1);

    typedef struct packed {
        logic [CH_W-1:0] ctx;
        logic [4:0]      vhi;
        logic            ovf;
        logic            ack_d;
    } top_t;

    top_t d, q;

    reg_addr_e       a;
    logic            ack, ack_start;
    logic            we_ctx, we_vec, we_eos, we_stk, pop_go;
    logic [DP_W-1:0] dp_stat, dp_en;
    logic [CC_W-1:0] cc_stat, cc_en;
    logic            dp_pend, cc_pend;
    logic [CH_W-1:0] stk_top;
    logic [CW-1:0]   depth;
    logic            stk_full, stk_empty;
    logic [7:0]      vec;

    assign a         = reg_addr_e'(addr);
    assign ack       = ~ack_n;
    assign ack_start = ack & ~q.ack_d;
    assign we_ctx    = wr_en && (a == A_CTX);
    assign we_vec    = wr_en && (a == A_VEC);
    assign we_eos    = wr_en && (a == A_EOS);
    assign we_stk    = wr_en && (a == A_STK);
    assign pop_go    = we_eos && !ack_start;

    svc_stat #(.W(DP_W)) u_dp_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (dp_evt),
        .clr_we (wr_en && (a == A_DPS)),
        .en_we  (wr_en && (a == A_DPE)),
        .wdata  (wdata[DP_W-1:0]),
        .stat   (dp_stat),
        .en     (dp_en),
        .pend   (dp_pend)
    );

    svc_stat #(.W(CC_W)) u_cc_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (cc_evt),
        .clr_we (wr_en && (a == A_CCS)),
        .en_we  (wr_en && (a == A_CCE)),
        .wdata  (wdata[CC_W-1:0]),
        .stat   (cc_stat),
        .en     (cc_en),
        .pend   (cc_pend)
    );

    svc_ctx_stack #(.DEPTH(STK_DEPTH), .W(CH_W)) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (ack_start),
        .pop      (pop_go),
        .push_val (q.ctx),
        .top_val  (stk_top),
        .depth    (depth),
        .full     (stk_full),
        .empty    (stk_empty)
    );

    always_comb begin
        d       = q;
        d.ack_d = ack;
        if (we_vec) d.vhi = wdata[7:3];
        if (ack_start)                d.ctx = '0;
        else if (pop_go && !stk_empty) d.ctx = stk_top;
        else if (we_ctx)              d.ctx = wdata[CH_W-1:0];
        if (ack_start && stk_full)    d.ovf = 1'b1;
        else if (we_stk && wdata[7])  d.ovf = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign vec      = {q.vhi, 1'b0, cc_pend, dp_pend};
    assign svc_req  = (dp_pend | cc_pend) && stk_empty;
    assign ctx_chan = q.ctx;

    always_comb begin
        rdata = '0;
        if (ack) begin
            rdata = vec;
        end else if (rd_en) begin
            case (a)
                A_CTX: rdata = DW'(q.ctx);
                A_VEC: rdata = vec;
                A_DPS: rdata = DW'(dp_stat);
                A_DPE: rdata = DW'(dp_en);
                A_CCS: rdata = DW'(cc_stat);
                A_CCE: rdata = DW'(cc_en);
                A_STK: begin
                    rdata[CW-1:0] = depth;
                    rdata[7]      = q.ovf;
                end
                default: rdata = '0;
            endcase
        end
    end

    p_ack_ctx0_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !q.ack_d) |=> (ctx_chan == '0));

    p_one_push_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && q.ack_d && !we_eos) |=> $stable(depth));

    p_req_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        svc_req |-> (depth == '0));

    p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ovf && !(we_stk && wdata[7])) |=> q.ovf);

    p_eos_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_start && !stk_full) |=> (depth == $past(depth) + 1'b1));
endmodule

// File: tb/tb_svc_ctx_ctrl.sv
module tb_svc_ctx_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       ack_n = 1'b1;
    logic [3:0] dp_evt = '0, cc_evt = '0;
    logic       svc_req;
    logic [1:0] ctx_chan;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    svc_ctx_ctrl dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .ack_n(ack_n), .dp_evt(dp_evt),
        .cc_evt(cc_evt), .svc_req(svc_req), .ctx_chan(ctx_chan)
    );

    // row: dp_evt[19:16] cc_evt[15:12] dp_en[11:8] cc_en[7:4] req[3] src[2:0]
    localparam logic [19:0] TBL [6] = '{
        20'h1_0_1_0_9, 20'h2_0_1_0_0, 20'h0_4_0_4_A,
        20'h8_1_8_1_B, 20'h6_8_4_0_9, 20'h0_0_F_F_0
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] ad, input logic [7:0] dt);
        @(negedge clk);
        wr_en = 1'b1; addr = ad; wdata = dt;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] ad, output logic [7:0] dt);
        rd_en = 1'b1; addr = ad;
        #1 dt = rdata;
        rd_en = 1'b0;
    endtask

    task automatic pulse(input logic [3:0] dp, input logic [3:0] cc);
        @(negedge clk);
        dp_evt = dp; cc_evt = cc;
        @(negedge clk);
        dp_evt = '0; cc_evt = '0;
    endtask

    task automatic ack_cycle(input int hold, input logic [7:0] exp_vec, input string req);
        @(negedge clk);
        ack_n = 1'b0;
        #1 chk(req, rdata, exp_vec);
        repeat (hold) @(negedge clk);
        ack_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 svc_req", 8'(svc_req), 8'h0);
        chk("R1 ctx", 8'(ctx_chan), 8'h0);
        rd(3'd7, v); chk("R1 stack", v, 8'h00);
        rd(3'd2, v); chk("R1 dp status", v, 8'h00);
        rd(3'd5, v); chk("R1 cc enable", v, 8'h00);

        // R10 context register
        wr(3'd0, 8'hFF);
        chk("R10 ctx_chan", 8'(ctx_chan), 8'h3);
        rd(3'd0, v); chk("R10 ctx read", v, 8'h03);

        // R4 vector high bits
        wr(3'd1, 8'hAD);
        rd(3'd1, v); chk("R4 vector idle", v, 8'hA8);

        // table: R2 R3 R4
        for (int i = 0; i < 6; i++) begin
            wr(3'd3, {4'h0, TBL[i][11:8]});
            wr(3'd5, {4'h0, TBL[i][7:4]});
            pulse(TBL[i][19:16], TBL[i][15:12]);
            chk("R3 table svc_req", 8'(svc_req), 8'(TBL[i][3]));
            rd(3'd1, v); chk("R4 table src", v, {5'h15, TBL[i][2:0]});
            rd(3'd2, v); chk("R2 table dp status", v, {4'h0, TBL[i][19:16]});
            wr(3'd2, 8'h0F);
            wr(3'd4, 8'h0F);
            rd(3'd4, v); chk("R2 table cc cleared", v, 8'h00);
        end

        // R2 partial clear and set-over-clear
        wr(3'd3, 8'h00);
        wr(3'd5, 8'h00);
        pulse(4'h5, 4'h0);
        wr(3'd2, 8'h01);
        rd(3'd2, v); chk("R2 w1c partial", v, 8'h04);
        @(negedge clk);
        dp_evt = 4'h8; wr_en = 1'b1; addr = 3'd2; wdata = 8'h0C;
        @(negedge clk);
        dp_evt = '0; wr_en = 1'b0;
        rd(3'd2, v); chk("R2 event beats clear", v, 8'h08);
        wr(3'd2, 8'h0F);

        // acknowledge: R5 R6 R3
        wr(3'd3, 8'h01);
        pulse(4'h1, 4'h0);
        chk("R3 request raised", 8'(svc_req), 8'h1);
        ack_cycle(2, 8'hA9, "R5 vector during ack");
        chk("R6 ctx forced 0", 8'(ctx_chan), 8'h0);
        chk("R3 no request in service", 8'(svc_req), 8'h0);
        rd(3'd7, v); chk("R6 single push", v, 8'h01);

        wr(3'd0, 8'h02);
        ack_cycle(1, 8'hA9, "R5 second ack vector");
        wr(3'd0, 8'h01);
        ack_cycle(1, 8'hA9, "R5 third ack vector");
        chk("R7 ctx 0 on overflow", 8'(ctx_chan), 8'h0);
        rd(3'd7, v); chk("R7 overflow flag", v, 8'h82);

        // R8 pops
        wr(3'd6, 8'h00);
        chk("R8 pop restores 2", 8'(ctx_chan), 8'h2);
        wr(3'd6, 8'h5A);
        chk("R8 pop restores 3", 8'(ctx_chan), 8'h3);
        rd(3'd7, v); chk("R7 flag sticky", v, 8'h80);
        wr(3'd6, 8'hFF);
        chk("R8 empty pop ignored", 8'(ctx_chan), 8'h3);
        rd(3'd7, v); chk("R8 depth stays 0", v, 8'h80);
        chk("R3 request after service", 8'(svc_req), 8'h1);
        wr(3'd7, 8'h80);
        rd(3'd7, v); chk("R7 flag cleared", v, 8'h00);

        // R9 end-of-service coinciding with ack start
        wr(3'd0, 8'h01);
        ack_cycle(1, 8'hA9, "R5 ack before R9");
        @(negedge clk);
        ack_n = 1'b0; wr_en = 1'b1; addr = 3'd6; wdata = 8'h00;
        @(negedge clk);
        wr_en = 1'b0; ack_n = 1'b1;
        @(negedge clk);
        rd(3'd7, v); chk("R9 push kept pop dropped", v, 8'h02);
        wr(3'd6, 8'h00);
        chk("R9 first pop gives 0", 8'(ctx_chan), 8'h0);
        wr(3'd6, 8'h00);
        chk("R9 second pop gives 1", 8'(ctx_chan), 8'h1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule